// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block produces the destination byte address of every output pixel of a scaled image as it is written into a framebuffer. Source pixels arrive in raster order, with x changing fastest. The generator maps each pixel's position through one of four clockwise rotations. It can also reorder the result into 8x8 tiles, which is the layout a graphics engine expects. The address step follows the pixel format, which can be 4, 3 or 2 bytes per pixel.

Software loads a control word, a size word and a base address, and then pulses start. The generator then presents one address at a time with a valid flag. A downstream writer takes each address by raising accept in the same cycle. When the last pixel is accepted, the block pulses done and sets bit 0 of a small pending register. Software reads that register and clears it with a write.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset, valid_o and done_o are low and all pending bits read 0.
- R2: The control word holds the pixel format in bits [1:0], the rotation in bits [3:2] and the tiling enable in bit 4. With rotation 0 and tiling off, pixel (x,y) of a W x H image is sent to base + (y*W + x)*bpp, in raster order with x fastest.
- R3: With rotation 1 (90° clockwise), the destination is column H-1-y, row x of a buffer that is H pixels wide.
- R4: With rotation 2 (180°), the destination is column W-1-x, row H-1-y of a buffer that is W pixels wide.
- R5: With rotation 3 (270° clockwise), the destination is column y, row W-1-x of a buffer that is H pixels wide.
- R6: With tiling on, the pixel offset is (ty*(BW/8) + tx)*64 + ry*8 + rx. Here tx and rx are the rotated column divided by 8 and its remainder, ty and ry are the same for the rotated row, and BW is the buffer width after rotation.
- R7: Format 0 gives 4 bytes per pixel, format 1 gives 3 bytes, and formats 2 and 3 give 2 bytes.
- R8: The size word carries width-1 in bits [8:0] and height-1 in bits [25:16]; its other bits are ignored. Exactly W*H addresses are produced for any size from 1 to 512 in each dimension.
- R9: While valid_o is high and accept is low, the address and valid_o stay unchanged.
- R10: The cycle after the last accept, done_o is high for exactly one cycle, valid_o is low and pending bit 0 reads 1.
- R11: A pending write clears every bit written as 1 and leaves bits written as 0 unchanged. If a hardware set and a software clear of bit 0 happen in the same cycle, the bit ends up set.
- R12: A start pulse while a frame is in progress is ignored, together with any new control, size or base values presented with it. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 5 | Control word: format [1:0], rotation [3:2], tiling [4] |
| size_i | input | 32 | Size word: width-1 [8:0], height-1 [25:16] |
| base_i | input | AW | Framebuffer base byte address |
| start_i | input | 1 | Start request, taken only when idle |
| acc_i | input | 1 | Consumer accepts the current address |
| addr_o | output | AW | Destination byte address of the current pixel |
| valid_o | output | 1 | addr_o is meaningful |
| done_o | output | 1 | One-cycle pulse after the last accept |
| pend_wr_i | input | 1 | Write strobe of the pending register |
| pend_wdata_i | input | NIRQ | Write-1-to-clear mask |
| pend_o | output | NIRQ | Pending interrupt bits |

## Verification
The bench runs non-square images in every rotation. A design that swaps width and height in the rotated buffer, or reverses the wrong axis, then produces addresses that differ from the reference stream within the first row. Tiled frames are wider than one tile after rotation, so a tile grid taken from the pre-rotation width shows up as wrong tile indices. Further frames cover the 3-byte and duplicate 2-byte formats, a 1x1 image and a 512-wide image with garbage in the unused size bits. They also include a restart attempt in the middle of a frame, which a design that re-latches its settings would follow into a new base address, and a clear of bit 0 in the same cycle as the final accept, which a design that lets the clear win would lose.

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
  parameter int AW   = 32,
  parameter int DW   = 10,
  parameter int NIRQ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      ctrl_i,
  input  logic [31:0]     size_i,
  input  logic [AW-1:0]   base_i,
  input  logic            start_i,
  input  logic            acc_i,
  output logic [AW-1:0]   addr_o,
  output logic            valid_o,
  output logic            done_o,
  input  logic            pend_wr_i,
  input  logic [NIRQ-1:0] pend_wdata_i,
  output logic [NIRQ-1:0] pend_o
);
  localparam int BWW = DW + 1;
  localparam int OW  = 2 * DW + 4;

  logic            busy;
  logic [DW-1:0]   x, y, wm1, hm1;
  logic [1:0]      rot, fmt;
  logic            tile;
  logic [AW-1:0]   base_q;
  logic            done_q;
  logic [NIRQ-1:0] pend_q;

  logic adv, last_x, last;
  assign adv    = busy & acc_i;
  assign last_x = (x == wm1);
  assign last   = last_x & (y == hm1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      x      <= '0;
      y      <= '0;
      wm1    <= '0;
      hm1    <= '0;
      rot    <= '0;
      fmt    <= '0;
      tile   <= 1'b0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= adv & last;
      if (!busy && start_i) begin
        busy   <= 1'b1;
        x      <= '0;
        y      <= '0;
        wm1    <= DW'(size_i[8:0]);
        hm1    <= DW'(size_i[25:16]);
        fmt    <= ctrl_i[1:0];
        rot    <= ctrl_i[3:2];
        tile   <= ctrl_i[4];
        base_q <= base_i;
      end else if (adv) begin
        if (last) busy <= 1'b0;
        if (last_x) begin
          x <= '0;
          y <= y + 1'b1;
        end else begin
          x <= x + 1'b1;
        end
      end
    end
  end

  logic [NIRQ-1:0] clr_mask, set_mask;
  assign clr_mask = pend_wr_i ? pend_wdata_i : '0;
  assign set_mask = {{(NIRQ-1){1'b0}}, adv & last};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  logic [DW-1:0]  dx, dy;
  logic [BWW-1:0] bw;

  always_comb begin
    case (rot)
      2'd1: begin dx = hm1 - y; dy = x;       bw = BWW'(hm1) + 1'b1; end
      2'd2: begin dx = wm1 - x; dy = hm1 - y; bw = BWW'(wm1) + 1'b1; end
      2'd3: begin dx = y;       dy = wm1 - x; bw = BWW'(hm1) + 1'b1; end
      default: begin dx = x;    dy = y;       bw = BWW'(wm1) + 1'b1; end
    endcase
  end

  logic [OW-1:0] lin_off, tile_off, off, byte_off;

  assign lin_off  = OW'(dy) * OW'(bw) + OW'(dx);
  assign tile_off = ((OW'(dy[DW-1:3]) * OW'(bw[BWW-1:3]) + OW'(dx[DW-1:3])) << 6)
                  + OW'({dy[2:0], dx[2:0]});
  assign off      = tile ? tile_off : lin_off;

  always_comb begin
    case (fmt)
      2'd0:    byte_off = off << 2;
      2'd1:    byte_off = (off << 1) + off;
      default: byte_off = off << 1;
    endcase
  end

  assign addr_o  = base_q + AW'(byte_off);
  assign valid_o = busy;
  assign done_o  = done_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/fb_addr_gen_chk.sv
module fb_addr_gen_chk #(
  parameter int AW   = 32,
  parameter int NIRQ = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            acc_i,
  input logic [AW-1:0]   addr_o,
  input logic            valid_o,
  input logic            done_o,
  input logic            pend_wr_i,
  input logic [NIRQ-1:0] pend_wdata_i,
  input logic [NIRQ-1:0] pend_o
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !acc_i |=> valid_o && $stable(addr_o));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> pend_o[0]);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);

  assert_clear_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr_i && pend_wdata_i[NIRQ-1] |=> !pend_o[NIRQ-1]);

  assert_keep_bit0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[0] && !pend_wr_i |=> pend_o[0]);

  assert_restart_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && start_i && !acc_i |=> valid_o && $stable(addr_o));
endmodule

bind fb_addr_gen fb_addr_gen_chk #(.AW(AW), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_i(acc_i),
  .addr_o(addr_o), .valid_o(valid_o), .done_o(done_o),
  .pend_wr_i(pend_wr_i), .pend_wdata_i(pend_wdata_i), .pend_o(pend_o)
);

// File: tb/sim_fb_addr_gen.sv
module sim_fb_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ctrl_i = '0;
  logic [31:0] size_i = '0;
  logic [31:0] base_i = '0;
  logic        start_i = 1'b0;
  logic        acc_i = 1'b0;
  logic [31:0] addr_o;
  logic        valid_o;
  logic        done_o;
  logic        pend_wr_i = 1'b0;
  logic [2:0]  pend_wdata_i = '0;
  logic [2:0]  pend_o;

  int checks = 0;
  int fails  = 0;
  int dones  = 0;
  bit prev_done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fb_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .size_i(size_i), .base_i(base_i),
    .start_i(start_i), .acc_i(acc_i), .addr_o(addr_o), .valid_o(valid_o),
    .done_o(done_o), .pend_wr_i(pend_wr_i), .pend_wdata_i(pend_wdata_i), .pend_o(pend_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_addr(input int rot, input int tl, input int fmt,
      input int w, input int h, input int x, input int y, input logic [31:0] b);
    int dx, dy, bw, off, bpp;
    case (rot)
      1: begin dx = h-1-y; dy = x;     bw = h; end
      2: begin dx = w-1-x; dy = h-1-y; bw = w; end
      3: begin dx = y;     dy = w-1-x; bw = h; end
      default: begin dx = x; dy = y;   bw = w; end
    endcase
    if (tl != 0) off = ((dy/8)*(bw/8) + dx/8)*64 + (dy%8)*8 + dx%8;
    else         off = dy*bw + dx;
    bpp = (fmt == 0) ? 4 : (fmt == 1) ? 3 : 2;
    return b + 32'(off*bpp);
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        if (exp_q.size() == 0) check("R8 extra address", addr_o, 32'hFFFF_FFFF);
        else if (acc_i) begin
          check(tag_q[0], addr_o, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end else check({tag_q[0], " R9 hold"}, addr_o, exp_q[0]);
      end
      if (done_o) begin
        dones++;
        check("R10 queue empty at done", 32'(exp_q.size()), 0);
        check("R10 valid low at done", 32'(valid_o), 0);
        check("R10 pending bit0", 32'(pend_o[0]), 1);
      end
      if (prev_done) check("R10 done one cycle", 32'(done_o), 0);
      prev_done = done_o;
    end
  end

  task automatic pend_write(input logic [2:0] m);
    @(posedge clk); #2;
    pend_wr_i = 1'b1; pend_wdata_i = m;
    @(posedge clk); #2;
    pend_wr_i = 1'b0; pend_wdata_i = '0;
  endtask

  task automatic run_frame(input string tag, input int rot, input int tl, input int fmt,
      input int w, input int h, input logic [31:0] b, input bit stall,
      input bit clr_end, input bit restart);
    int d0, k;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        exp_q.push_back(ref_addr(rot, tl, fmt, w, h, x, y, b));
        tag_q.push_back(tag);
      end
    d0 = dones;
    @(posedge clk); #2;
    ctrl_i  = 5'({tl[0], rot[1:0], fmt[1:0]});
    size_i  = 32'hFC00_FE00 | (32'(h-1) << 16) | 32'(w-1);
    base_i  = b;
    start_i = 1'b1;
    k = 0;
    while (exp_q.size() > 0 && k < 20000) begin
      @(posedge clk); #2;
      acc_i = stall ? ((k % 3) != 1) : 1'b1;
      if (restart && k == 3) begin
        start_i = 1'b1; base_i = b + 32'h4000; ctrl_i = 5'h1F; size_i = 32'h0003_0003;
      end else start_i = 1'b0;
      if (clr_end && exp_q.size() == 1 && acc_i) begin
        pend_wr_i = 1'b1; pend_wdata_i = 3'b001;
      end else begin
        pend_wr_i = 1'b0; pend_wdata_i = '0;
      end
      k++;
    end
    acc_i = 1'b0; start_i = 1'b0; pend_wr_i = 1'b0; pend_wdata_i = '0;
    repeat (3) @(posedge clk);
    #2;
    check({tag, " R10 one done per frame"}, 32'(dones - d0), 1);
    check({tag, " R10 idle after frame"}, 32'(valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 32'(valid_o), 0);
    check("R1 done after reset", 32'(done_o), 0);
    check("R1 pending after reset", 32'(pend_o), 0);

    run_frame("R2 R7 R8 rot0 fmt0", 0, 0, 0, 5, 3, 32'h0000_1000, 0, 0, 0);
    pend_write(3'b000);
    check("R11 write 0 keeps bit", 32'(pend_o), 1);
    pend_write(3'b001);
    check("R11 write 1 clears bit", 32'(pend_o), 0);

    run_frame("R3 R7 rot1 fmt1", 1, 0, 1, 4, 3, 32'h0002_0000, 1, 0, 0);
    pend_write(3'b111);
    run_frame("R4 R7 rot2 fmt2", 2, 0, 2, 6, 2, 32'h0003_0010, 1, 0, 0);
    pend_write(3'b111);
    run_frame("R5 R7 rot3 fmt3", 3, 0, 3, 3, 5, 32'h0004_0000, 0, 0, 0);
    pend_write(3'b111);
    run_frame("R6 tiled rot0", 0, 1, 0, 16, 8, 32'h0010_0000, 0, 0, 0);
    pend_write(3'b111);
    run_frame("R6 tiled rot3", 3, 1, 1, 8, 16, 32'h0020_0000, 1, 0, 0);
    pend_write(3'b111);
    run_frame("R6 tiled rot1", 1, 1, 2, 16, 24, 32'h0030_0000, 0, 0, 0);
    pend_write(3'b111);
    check("R11 cleared before set-wins test", 32'(pend_o), 0);
    run_frame("R8 R11 1x1", 0, 0, 0, 1, 1, 32'h0040_0000, 0, 1, 0);
    check("R11 set wins over clear", 32'(pend_o[0]), 1);
    pend_write(3'b111);
    run_frame("R8 R12 512 wide restart", 2, 0, 0, 512, 2, 32'h0050_0000, 1, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule